// File: doc/BRIEF.md
# System Tick Timer

A periodic down-counter for generating a regular time base, typically used by an operating-system scheduler. Software programs a reload value and picks the count clock. The count clock is either every processor clock cycle or a one-cycle reference strobe that is synchronous to the processor clock. Software then enables counting. Each time the counter steps from one to zero, a sticky flag is set. If interrupts are enabled, a single-cycle request pulse also goes out to the exception logic. On the count event that follows zero, the counter reloads.

The block sits behind a simple word-wide read/write port with byte addresses. Reads return data combinationally in the same cycle as the read strobe. Writes take effect at the clock edge.

Four registers are mapped:
- control/status at 0x10;
- reload at 0x14;
- live counter at 0x18;
- a read-only calibration word at 0x1C, whose contents are fixed by parameters.

The counter width is a parameter from 2 to 24 bits.

Top module: `tick_timer`

## Requirements
- R1: After reset, control, reload and counter all read zero, the flag is clear and `tick_irq` is low.
- R2: The control word at 0x10 holds run enable in bit 0, interrupt enable in bit 1 and clock source in bit 2 (0 = reference strobe, 1 = processor clock). These bits read back as written, and bits 15..3 and 31..17 read zero.
- R3: A count event happens only while bit 0 is set. With source 0 it happens only in a cycle where `ref_tick` is high; with source 1 it happens on every clock cycle. Without a count event the counter holds.
- R4: A count event while the counter is zero loads the reload value. This load sets no flag and raises no request.
- R5: A count event while the counter is one takes it to zero and sets the flag, which reads as bit 16 of 0x10.
- R6: A read of 0x10 returns the flag as it stood before the read, and then clears it.
- R7: Any write to 0x18 sets the counter to zero and clears the flag, whatever the write data.
- R8: `tick_irq` is high for exactly one cycle after each one-to-zero step, and only when bit 1 was set. It never rises otherwise.
- R9: With a reload value of zero, the counter stays at zero after its next wrap and produces no further flag or request.
- R10: Address 0x1C reads the calibration word: the 10 ms count in bits 23..0, the skew indicator in bit 30 and the no-reference indicator in bit 31. Writes to it change nothing.
- R11: Address 0x18 reads the live count, and 0x14 reads back the low counter-width bits of the last write. Upper bits and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads of 0x10 clear the flag) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ref_tick | input | 1 | One-cycle reference count strobe |
| tick_irq | output | 1 | One-cycle exception request |

## Verification
The bench targets the wrap boundary. A design off by one would set the flag a tick early or late, or would raise a request on the load from zero instead of on the step into zero. A reload of zero must freeze the counter; a wrong design would keep wrapping or underflow to all ones. A clear that ignored the write data, or that forgot the flag, would leave a stale flag visible. Reading the flag twice shows whether the read itself clears it. Holding the counter with the reference strobe low, and with the counter disabled, shows whether the source gating leaks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned OFS_CTRL    = 32'h10;
  localparam int unsigned OFS_RELOAD  = 32'h14;
  localparam int unsigned OFS_CURRENT = 32'h18;
  localparam int unsigned OFS_CAL     = 32'h1C;
  localparam int unsigned FLAG_BIT    = 16;
  localparam int unsigned CAL_FIELD_W = 24;
  localparam int unsigned SKEW_BIT    = 30;
  localparam int unsigned NOREF_BIT   = 31;

  // packed MSB first: clk_src is bit 2, irq_en bit 1, run bit 0
  typedef struct packed {
    logic clk_src;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel
  import tick_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  ref_tick,
  output logic  count_evt
);
  function automatic logic gate(input logic run, input logic src, input logic strobe);
    return run && (src ? 1'b1 : strobe);
  endfunction

  assign count_evt = gate(ctrl.run, ctrl.clk_src, ref_tick);

  // R3
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clk_src && !ref_tick) |-> !count_evt);
  // R3
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |-> !count_evt);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_evt,
  input  logic             clear,
  input  logic             flag_rd_clr,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur_val,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - ONE;
  endfunction

  logic wrap_evt;
  logic load_evt;
  assign wrap_evt = count_evt && !clear && (cur_val == ONE);
  assign load_evt = count_evt && !clear && (cur_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cur_val <= '0;
    else if (clear)     cur_val <= '0;
    else if (count_evt) cur_val <= next_count(cur_val, reload_val);
  end

  // a wrap in the same cycle as a clear request wins, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag <= 1'b0;
    else if (wrap_evt)             flag <= 1'b1;
    else if (clear || flag_rd_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= wrap_evt && irq_en;
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag);
  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cur_val == $past(reload_val)));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_evt && !clear) |=> $stable(cur_val));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cur_val == '0) && !flag);
  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_clr && !wrap_evt) |=> !flag);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cur_val == '0) && flag);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned             ADDR_W    = 12,
  parameter int unsigned             CNT_W     = 24,
  parameter logic [CAL_FIELD_W-1:0]  CAL_TENMS = 24'h01D4C0,
  parameter bit                      CAL_SKEW  = 1'b1,
  parameter bit                      CAL_NOREF = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [WORD_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]   cur_val,
  input  logic               flag,
  output ctrl_t              ctrl,
  output logic [CNT_W-1:0]   reload_val,
  output logic               cur_clear,
  output logic               flag_rd_clr,
  output logic [WORD_W-1:0]  bus_rdata
);
  function automatic logic [WORD_W-1:0] build_cal();
    logic [WORD_W-1:0] w;
    w = '0;
    w[CAL_FIELD_W-1:0] = CAL_TENMS;
    w[SKEW_BIT]        = CAL_SKEW;
    w[NOREF_BIT]       = CAL_NOREF;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] widen(input logic [CNT_W-1:0] v);
    return WORD_W'(v);
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input ctrl_t c, input logic f);
    logic [WORD_W-1:0] w;
    w = '0;
    w[2:0]      = c;
    w[FLAG_BIT] = f;
    return w;
  endfunction

  localparam logic [WORD_W-1:0] CAL_WORD = build_cal();

  logic sel_ctrl, sel_reload, sel_cur, sel_cal;
  assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign sel_cur    = (bus_addr == ADDR_W'(OFS_CURRENT));
  assign sel_cal    = (bus_addr == ADDR_W'(OFS_CAL));

  assign cur_clear   = bus_wr && sel_cur;
  assign flag_rd_clr = bus_rd && sel_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      reload_val <= '0;
    end else if (bus_wr) begin
      if (sel_ctrl)   ctrl       <= ctrl_t'(bus_wdata[2:0]);
      if (sel_reload) reload_val <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctrl)   bus_rdata = status_word(ctrl, flag);
      if (sel_reload) bus_rdata = widen(reload_val);
      if (sel_cur)    bus_rdata = widen(cur_val);
      if (sel_cal)    bus_rdata = CAL_WORD;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[WORD_W-1:CNT_W];

  // R2
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctrl) |=> (ctrl == $past(bus_wdata[2:0])));
  // R11
  reload_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_reload) |=> (reload_val == $past(bus_wdata[CNT_W-1:0])));
  // R2
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel_ctrl) |=> $stable(ctrl));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 12,
  parameter int unsigned            CNT_W     = 24,
  parameter logic [CAL_FIELD_W-1:0] CAL_TENMS = 24'h01D4C0,
  parameter bit                     CAL_SKEW  = 1'b1,
  parameter bit                     CAL_NOREF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  output logic              tick_irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cur_val;
  logic             cur_clear;
  logic             flag_rd_clr;
  logic             flag;
  logic             count_evt;

  tick_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CAL_TENMS(CAL_TENMS), .CAL_SKEW(CAL_SKEW), .CAL_NOREF(CAL_NOREF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .cur_val(cur_val), .flag(flag),
    .ctrl(ctrl), .reload_val(reload_val), .cur_clear(cur_clear),
    .flag_rd_clr(flag_rd_clr), .bus_rdata(bus_rdata)
  );

  tick_src_sel u_src (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .ref_tick(ref_tick), .count_evt(count_evt)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_evt(count_evt),
    .clear(cur_clear), .flag_rd_clr(flag_rd_clr), .irq_en(ctrl.irq_en),
    .reload_val(reload_val), .cur_val(cur_val), .flag(flag), .irq(tick_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !tick_irq && (cur_val == '0));
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam logic [11:0] A_CTRL = 12'h010;
  localparam logic [11:0] A_REL  = 12'h014;
  localparam logic [11:0] A_CUR  = 12'h018;
  localparam logic [11:0] A_CAL  = 12'h01C;
  localparam int NV = 8;
  localparam logic [23:0] V_REL [NV] = '{24'd5, 24'd5, 24'd5, 24'd5, 24'd0, 24'd1, 24'd1, 24'hFFFFFF};
  localparam int          V_N   [NV] = '{1, 3, 6, 7, 3, 2, 3, 2};
  localparam logic [23:0] V_EXP [NV] = '{24'd5, 24'd3, 24'd0, 24'd5, 24'd0, 24'd0, 24'd1, 24'hFFFFFE};
  localparam logic        V_FLG [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, ref_tick = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tick_irq;
  int errs = 0, total = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .tick_irq(tick_irq)
  );

  always @(negedge clk) if (tick_irq) irq_cnt++;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic pulse();
    ref_tick = 1'b1;
    step();
    ref_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_REL, d);  chk("R1 reload", d, 32'h0);
    rd(A_CUR, d);  chk("R1 current", d, 32'h0);
    chk("R1 irq", {31'b0, tick_irq}, 32'h0);
    // R10 calibration word and read-only behaviour
    rd(A_CAL, d); chk("R10 cal", d, 32'h4001D4C0);
    wr(A_CAL, 32'hFFFFFFFF);
    rd(A_CAL, d); chk("R10 cal write ignored", d, 32'h4001D4C0);
    // R11 unmapped and reload readback
    rd(12'h020, d); chk("R11 unmapped", d, 32'h0);
    wr(A_REL, 32'hFF123456);
    rd(A_REL, d); chk("R11 reload readback", d, 32'h00123456);
    // R2 control bits read back, others zero
    wr(A_CTRL, 32'hFFFFFFF6);
    rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h6);
    // R3 disabled: ticks do nothing
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd5);
    wr(A_CUR, 32'h0);
    repeat (3) pulse();
    rd(A_CUR, d); chk("R3 disabled hold", d, 32'h0);

    // table walk: external strobe, no interrupt (R3 R4 R5 R9)
    wr(A_CTRL, 32'h1);
    irq_cnt = 0;
    for (int i = 0; i < NV; i++) begin
      wr(A_REL, {8'h0, V_REL[i]});
      wr(A_CUR, 32'h00000ABC);
      repeat (V_N[i]) pulse();
      repeat (2) step();
      rd(A_CUR, d);  chk($sformatf("R4/R9 vec%0d count", i), d, {8'h0, V_EXP[i]});
      rd(A_CTRL, d); chk($sformatf("R5 vec%0d flag", i), d, {15'b0, V_FLG[i], 16'h1});
    end
    chk("R8 no irq with bit1 clear", irq_cnt, 0);

    // R8 single pulse on wrap, none on load
    wr(A_CTRL, 32'h3);
    wr(A_REL, 32'd2);
    wr(A_CUR, 32'h0);
    pulse(); chk("R4 no irq on load", {31'b0, tick_irq}, 32'h0);
    pulse(); chk("R8 no irq at one", {31'b0, tick_irq}, 32'h0);
    pulse(); chk("R8 irq on wrap", {31'b0, tick_irq}, 32'h1);
    step();  chk("R8 irq one cycle", {31'b0, tick_irq}, 32'h0);
    // R6 read clears flag
    rd(A_CTRL, d); chk("R6 first read", d, 32'h00010003);
    rd(A_CTRL, d); chk("R6 second read", d, 32'h00000003);
    // R7 current write clears count and flag
    wr(A_REL, 32'd1);
    wr(A_CUR, 32'h0);
    repeat (3) pulse();
    wr(A_CUR, 32'h55);
    rd(A_CUR, d);  chk("R7 count cleared", d, 32'h0);
    rd(A_CTRL, d); chk("R7 flag cleared", d, 32'h00000003);
    // R9 zero reload halts, no request
    wr(A_REL, 32'd0);
    irq_cnt = 0;
    repeat (4) pulse();
    rd(A_CUR, d); chk("R9 halted", d, 32'h0);
    chk("R9 no irq", irq_cnt, 0);
    // R3 processor clock source
    wr(A_CTRL, 32'h0);
    wr(A_REL, 32'd9);
    wr(A_CUR, 32'h0);
    wr(A_CTRL, 32'h5);
    repeat (4) step();
    rd(A_CUR, d); chk("R3 processor clock", d, 32'd6);
    wr(A_CTRL, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule